// File: doc/BRIEF.md
# External Trigger Timestamp Capture

This block stamps an external event with the time of day. A free-running time-of-day counter (32-bit seconds, 32-bit nanoseconds) is fed in from outside. Any of twelve general-purpose pins can be routed to the trigger input. The routed pin passes through a two-flop synchroniser and an edge detector. When the chosen edge arrives, both halves of the time are frozen into a capture register.

The capture is held until software acknowledges it. Until then, later edges are dropped, so a read-out that spans several accesses always returns one coherent time. Software sees a sticky valid flag, reads the time as four 16-bit words, and writes the acknowledge to arm the block again. The register port is a plain single-cycle write strobe and a combinational read address. The management bus that drives it lies outside this block.

Top module: `ext_trig_stamp`

## Requirements
- R1: After reset, the config word, all four capture words, the control word and every pin function word read as zero.
- R2: Pin i has a function word at address 16+i that reads back as written. The pin drives the trigger only while that word equals 0x8041 (bit 15 enable, bit 6 timing function, signal code 0x01). Any other value, including 0, leaves the pin disconnected.
- R3: A trigger edge is captured on the third rising clock edge after the pin changes, counting the synchroniser and edge-detect registers. The valid flag reads 1 only from that point on.
- R4: Config word address 0, bit 0 selects the edge: 0 captures rising edges only and 1 captures falling edges only. An edge of the other kind does not capture.
- R5: The captured nanoseconds read at address 1 (bits 15:0) and address 2 (bits 31:16). The captured seconds read at address 3 (bits 15:0) and address 4 (bits 31:16). Each holds the time-of-day value present in the capture cycle.
- R6: Control word address 5, bit 0 is a valid flag. A capture sets it, and it stays set without further events.
- R7: While valid is set, further trigger edges change neither the stored time nor the flag.
- R8: Writing the control word with bit 0 set clears valid. Writing it with bit 0 clear has no effect.
- R9: If an acknowledge write and a trigger edge fall in the same cycle, the new time is captured and valid stays set.
- R10: When several pins are routed, the lowest-index routed pin alone drives the trigger. Edges on unrouted pins are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | 12 | General-purpose pins, asynchronous |
| tod_sec | input | 32 | Time of day, seconds |
| tod_ns | input | 32 | Time of day, nanoseconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data for rd_addr, combinational |

## Verification
An acknowledge write and a fresh trigger edge can land on the same clock edge. The two then compete for the valid flag and the capture register. The bench provokes this by taking the pin low for falling-edge mode and holding the acknowledge write strobe across the third clock edge after that change. That is the edge on which the detector fires. The case is judged correct only if valid still reads 1 afterwards and the capture words hold the newly supplied time, not the old one.

// File: rtl/ext_trig_stamp.sv
module ext_trig_stamp #(
  parameter int N_PINS = 12,
  parameter int ADDR_W = 5,
  parameter int FUNC_BASE = 16,
  parameter logic [15:0] ROUTE_CODE = 16'h8041
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins,
  input  logic [31:0]       tod_sec,
  input  logic [31:0]       tod_ns,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_NS_LO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_NS_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_S_LO  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_S_HI  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(5);

  logic [15:0]       func [N_PINS];
  logic [N_PINS-1:0] routed;
  logic              edge_fall, trig, s1, s2, prev, hit, ack, valid;
  logic [31:0]       cap_ns, cap_sec;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    always_ff @(posedge clk)
      if (!rst_n) func[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(FUNC_BASE + i)) func[i] <= wr_data;
    assign routed[i] = (func[i] == ROUTE_CODE);
  end

  always_comb begin
    trig = 1'b0;
    for (int i = N_PINS - 1; i >= 0; i--)
      if (routed[i]) trig = pins[i];
  end

  always_ff @(posedge clk)
    if (!rst_n) {s1, s2, prev} <= '0;
    else {s1, s2, prev} <= {trig, s1, s2};

  assign hit = edge_fall ? (prev & ~s2) : (s2 & ~prev);
  assign ack = wr_en && wr_addr == A_CTRL && wr_data[0];

  always_ff @(posedge clk)
    if (!rst_n) begin
      edge_fall <= 1'b0;
      valid     <= 1'b0;
      cap_ns    <= '0;
      cap_sec   <= '0;
    end else begin
      if (wr_en && wr_addr == A_CFG) edge_fall <= wr_data[0];
      if (hit && (!valid || ack)) begin
        valid   <= 1'b1;
        cap_ns  <= tod_ns;
        cap_sec <= tod_sec;
      end else if (ack) begin
        valid <= 1'b0;
      end
    end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG:   rd_data = {15'd0, edge_fall};
      A_NS_LO: rd_data = cap_ns[15:0];
      A_NS_HI: rd_data = cap_ns[31:16];
      A_S_LO:  rd_data = cap_sec[15:0];
      A_S_HI:  rd_data = cap_sec[31:16];
      A_CTRL:  rd_data = {15'd0, valid};
      default:
        for (int i = 0; i < N_PINS; i++)
          if (rd_addr == ADDR_W'(FUNC_BASE + i)) rd_data = func[i];
    endcase
  end
endmodule

// File: rtl/ext_trig_stamp_chk.sv
module ext_trig_stamp_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       tod_ns,
  input logic [31:0]       tod_sec,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              hit,
  input logic              valid,
  input logic [31:0]       cap_ns,
  input logic [31:0]       cap_sec
);
  logic ack;
  assign ack = wr_en && wr_addr == ADDR_W'(5) && wr_data[0];

  AST_CAPTURE_TAKES_TOD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !valid) |=> (valid && cap_ns == $past(tod_ns) && cap_sec == $past(tod_sec))); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> valid); // R6
  AST_HOLD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> ($stable(cap_ns) && $stable(cap_sec))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ack && !hit) |=> !valid); // R8
  AST_ACK_AND_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ack && hit) |=> (valid && cap_ns == $past(tod_ns))); // R9
endmodule

bind ext_trig_stamp ext_trig_stamp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tod_ns(tod_ns), .tod_sec(tod_sec),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit),
  .valid(valid), .cap_ns(cap_ns), .cap_sec(cap_sec)
);

// File: tb/ext_trig_stamp_test.sv
`timescale 1ns/100ps
module ext_trig_stamp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pins = '0;
  logic [31:0] tod_sec = '0, tod_ns = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed { logic [4:0] a; logic [15:0] d; logic [7:0] r; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  ext_trig_stamp uut (.clk(clk), .rst_n(rst_n), .pins(pins), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  initial forever begin
    @(negedge clk);
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      rd_addr = it.a;
      #1;
      total++;
      if (rd_data !== it.d) begin
        bad++;
        $display("FAIL R%0d addr=%0d actual=%h expected=%h", it.r, it.a, rd_data, it.d);
      end
    end
  end

  task automatic chk(input logic [4:0] a, input logic [15:0] d, input logic [7:0] r);
    q.push_back('{a: a, d: d, r: r});
    wait (q.size() == 0);
    #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stamp(input logic [31:0] ns, input logic [31:0] s, input logic [7:0] r);
    chk(5'd1, ns[15:0], r);  chk(5'd2, ns[31:16], r);
    chk(5'd3, s[15:0], r);   chk(5'd4, s[31:16], r);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a <= 5; a++) chk(5'(a), 16'h0, 1);
    chk(5'd16, 16'h0, 1); chk(5'd27, 16'h0, 1);

    // R2 routing and read-back
    wr(5'd19, 16'h8041);
    chk(5'd19, 16'h8041, 2);
    wr(5'd21, 16'h8012);
    chk(5'd21, 16'h8012, 2);

    // R5/R6 rising capture on pin 3
    tod_ns = 32'h1234_5678; tod_sec = 32'h0000_00AB;
    @(negedge clk); pins[3] = 1'b1;
    idle(4);
    chk(5'd5, 16'h1, 6);
    stamp(32'h1234_5678, 32'h0000_00AB, 5);

    // R7 further edges ignored while held
    tod_ns = 32'h0BAD_0BAD; tod_sec = 32'h0000_0FFF;
    @(negedge clk); pins[3] = 1'b0; idle(4);
    pins[3] = 1'b1; idle(4);
    stamp(32'h1234_5678, 32'h0000_00AB, 7);
    chk(5'd5, 16'h1, 6);

    // R8 ack with bit0 clear is ignored, bit0 set clears
    wr(5'd5, 16'hFFFE);
    chk(5'd5, 16'h1, 8);
    pins[3] = 1'b0;
    wr(5'd5, 16'h0001);
    idle(4);
    chk(5'd5, 16'h0, 8);

    // R3 exact latency
    tod_ns = 32'h0000_0333; tod_sec = 32'h0000_0003;
    @(negedge clk); pins[3] = 1'b1;
    chk(5'd5, 16'h0, 3);
    chk(5'd5, 16'h0, 3);
    chk(5'd5, 16'h1, 3);
    chk(5'd1, 16'h0333, 3);
    wr(5'd5, 16'h0001);

    // R4 falling mode: rising ignored, falling captured
    wr(5'd0, 16'h0001);
    chk(5'd0, 16'h0001, 4);
    @(negedge clk); pins[3] = 1'b0; idle(4);
    wr(5'd5, 16'h0001);
    idle(2);
    tod_ns = 32'h4444_0001; tod_sec = 32'h0044_0000;
    @(negedge clk); pins[3] = 1'b1; idle(4);
    chk(5'd5, 16'h0, 4);
    @(negedge clk); pins[3] = 1'b0; idle(4);
    chk(5'd5, 16'h1, 4);
    stamp(32'h4444_0001, 32'h0044_0000, 4);

    // R9 ack and edge in the same cycle
    @(negedge clk); pins[3] = 1'b1; idle(4);
    tod_ns = 32'h9999_0009; tod_sec = 32'h0000_0909;
    @(negedge clk); pins[3] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 5'd5; wr_data = 16'h0001;
    @(negedge clk); wr_en = 1'b0;
    chk(5'd5, 16'h1, 9);
    stamp(32'h9999_0009, 32'h0000_0909, 9);

    // R10 priority and unrouted pins
    wr(5'd5, 16'h0001);
    wr(5'd0, 16'h0000);
    wr(5'd17, 16'h8041);
    tod_ns = 32'h0000_A0A0; tod_sec = 32'h0000_1010;
    @(negedge clk); pins[5] = 1'b1; idle(4);
    chk(5'd5, 16'h0, 10);
    pins[3] = 1'b1; idle(4);
    chk(5'd5, 16'h0, 10);
    pins[1] = 1'b1; idle(4);
    chk(5'd5, 16'h1, 10);
    stamp(32'h0000_A0A0, 32'h0000_1010, 10);

    // R2 writing 0 disconnects pin 1, pin 3 takes over
    pins = '0; idle(4);
    wr(5'd5, 16'h0001);
    wr(5'd17, 16'h0000);
    chk(5'd17, 16'h0, 2);
    @(negedge clk); pins[1] = 1'b1; idle(4);
    chk(5'd5, 16'h0, 2);
    pins[3] = 1'b1; idle(4);
    chk(5'd5, 16'h1, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule